// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Receiver

This block is the receive half of a reader that takes card replies sent as on/off keying of a load-modulation subcarrier. A hysteresis comparator turns the antenna envelope into a digital level, `cmp_in`. While the subcarrier is on, that level toggles many times in each bit period; while it is off, the level stays quiet. The block does not look for any start-of-frame marker, because the reply format has none. The reader pulses `start` when its own transmit frame ends. The block then waits a fixed turnaround delay and cuts time into back-to-back windows of `BIT_TICKS` clock cycles. In each window it counts level changes on the comparator input and decides the bit from that count. One clock cycle is one timer tick.

There are two modes, chosen by `ack_mode` when the trigger is taken. In reply mode, the caller supplies the number of bits in advance, for example 6 for a type reply or 12 for a data byte with its checksum. The block then collects exactly that many bits, least-significant first. In acknowledge mode, the block waits a longer delay and then scans up to `ACK_WINDOWS` windows for the first 1. It reports whether one was found and the elapsed time at that point, measured in bit periods. An all-zero reply looks the same as no card at all, so the block gives no presence indication. Keystream removal and checksum checking belong to the logic downstream.

The control is a four-state machine. **IDLE** moves to **WAIT** on `start` (transition *trigger*). **WAIT** moves to **BIT** in reply mode or to **SCAN** in acknowledge mode when the delay ends (transition *delay_done*). **BIT** returns to **IDLE** at the end of the last requested window (transition *frame_done*). **SCAN** returns to **IDLE** at the end of a window that decodes as 1 (transition *ack_hit*) or at the end of the last allowed window (transition *ack_timeout*).

Top module: `subcar_edge_rx`

## Requirements
- R1: While reset is active and after it is released, `done`, `data_out`, `bits_out`, `ack_ok` and `ack_steps` are all zero until the first completed reception.
- R2: In reply mode the first bit window starts `REPLY_WAIT` (477) cycles after the clock edge that takes `start`. Comparator changes during that delay are not counted. Windows of `BIT_TICKS` (142) cycles then follow one another with no gap.
- R3: A window decodes as 1 when it contains more than `EDGE_THRESH` (20) level changes of `cmp_in`, so 21 changes give 1. Otherwise it decodes as 0, so 20 changes give 0.
- R4: In reply mode, bit i of `data_out` holds window i, least-significant bit first. Bits above the requested count are 0 and `bits_out` equals the count. `done` goes high in the cycle after the edge that closes the last window, which is REPLY_WAIT + n*BIT_TICKS edges after the trigger edge.
- R5: The requested count `nbits` is clamped to the range 1 to `MAX_BITS` (32): 0 is taken as 1, and any value above 32 is taken as 32.
- R6: In acknowledge mode, windows start `ACK_WAIT` (5400) cycles after the trigger edge. The first window that decodes as 1 ends the scan with `done`=1 and `ack_ok`=1. `ack_steps` is then floor(E/BIT_TICKS), where E = ACK_WAIT + (w+1)*BIT_TICKS for window index w, and `data_out` and `bits_out` are 0.
- R7: If none of the `ACK_WINDOWS` (40) acknowledge windows decodes as 1, `done` goes high after the last one with `ack_ok`=0 and `ack_steps`=0.
- R8: A `start` pulse that arrives while a reception is in progress is ignored: the running reception keeps its timing and its result.
- R9: `done` is high for exactly one cycle per reception. All result outputs hold their values between `done` pulses.
- R10: In reply mode `ack_ok` and `ack_steps` are reported as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one timer tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Trigger at the end of the reader frame; taken only in IDLE |
| ack_mode | input | 1 | Sampled with start: 1 selects acknowledge search, 0 selects reply capture |
| nbits | input | 6 | Requested reply length, sampled with start, clamped to 1..32 |
| cmp_in | input | 1 | Hysteresis comparator output carrying the subcarrier |
| done | output | 1 | One-cycle pulse when a reception ends |
| data_out | output | 32 | Decoded reply, least-significant bit first |
| bits_out | output | 6 | Number of bits in data_out (0 for acknowledge) |
| ack_ok | output | 1 | Acknowledge found |
| ack_steps | output | 16 | Elapsed bit periods from the trigger to the acknowledge decision |

## Verification
The hardest situation to reach is a window whose edge count sits exactly on the threshold, because 20 and 21 changes must land inside one window without spilling into its neighbour. The comparator input is driven on falling clock edges from a per-window count table, and each toggle is placed a fixed number of cycles after the end of the delay. This makes the window boundaries exact. Acknowledge runs use a 1 in the first window, in a middle window and in the last allowed window, plus a run with no 1 at all, to cover the elapsed-time arithmetic at both ends. Toggles during the delay and a second trigger during a reception check that both are ignored.

// File: rtl/subcar_rx_pkg.sv
package subcar_rx_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT,
        S_BIT,
        S_SCAN
    } rx_state_e;
endpackage

// File: rtl/subcar_edge_cnt.sv
// Counts level changes of the comparator input within one bit window.
module subcar_edge_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level,
    input  logic             count_en,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt_now
);
    logic             prev_q;
    logic [CNT_W-1:0] cnt_q;
    logic             change;

    assign change  = level ^ prev_q;
    assign cnt_now = cnt_q + CNT_W'(count_en & change);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            prev_q <= level;
            if (clear)
                cnt_q <= '0;
            else
                cnt_q <= cnt_now;
        end
    end
endmodule

// File: rtl/subcar_step_cnt.sv
// Elapsed time since the trigger, expressed in whole bit periods.
module subcar_step_cnt #(
    parameter int BIT_TICKS = 142,
    parameter int STEP_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    output logic [STEP_W-1:0] steps_now
);
    localparam int DIV_W = $clog2(BIT_TICKS);

    logic [DIV_W-1:0]  div_q;
    logic [STEP_W-1:0] stp_q;
    logic              wrap;

    assign wrap      = (div_q == DIV_W'(BIT_TICKS - 1));
    assign steps_now = stp_q + STEP_W'(wrap);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            stp_q <= '0;
        end else if (clear) begin
            div_q <= '0;
            stp_q <= '0;
        end else begin
            div_q <= wrap ? '0 : div_q + DIV_W'(1);
            stp_q <= steps_now;
        end
    end
endmodule

// File: rtl/subcar_edge_rx.sv
module subcar_edge_rx
    import subcar_rx_pkg::*;
#(
    parameter int BIT_TICKS   = 142,
    parameter int REPLY_WAIT  = 477,
    parameter int ACK_WAIT    = 5400,
    parameter int EDGE_THRESH = 20,
    parameter int MAX_BITS    = 32,
    parameter int ACK_WINDOWS = 40,
    parameter int STEP_W      = 16,
    localparam int NB_W       = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                ack_mode,
    input  logic [NB_W-1:0]     nbits,
    input  logic                cmp_in,
    output logic                done,
    output logic [MAX_BITS-1:0] data_out,
    output logic [NB_W-1:0]     bits_out,
    output logic                ack_ok,
    output logic [STEP_W-1:0]   ack_steps
);
    localparam int MAX_DELAY = (ACK_WAIT > REPLY_WAIT) ? ACK_WAIT : REPLY_WAIT;
    localparam int MAX_SPAN  = (MAX_DELAY > BIT_TICKS) ? MAX_DELAY : BIT_TICKS;
    localparam int TMR_W     = $clog2(MAX_SPAN + 1);
    localparam int CNT_W     = $clog2(BIT_TICKS + 1);
    localparam int WIN_MAX   = (ACK_WINDOWS > MAX_BITS) ? ACK_WINDOWS : MAX_BITS;
    localparam int WIDX_W    = $clog2(WIN_MAX + 1);

    rx_state_e            state, nstate;
    logic [TMR_W-1:0]     timer;
    logic [WIDX_W-1:0]    widx;
    logic                 mode_q;
    logic [NB_W-1:0]      nbits_q;
    logic [NB_W-1:0]      n_req;
    logic [MAX_BITS-1:0]  data_q;
    logic [MAX_BITS-1:0]  bit_mask;
    logic [CNT_W-1:0]     cnt_now;
    logic [STEP_W-1:0]    steps_now;
    logic [TMR_W-1:0]     delay_last;
    logic                 in_window, win_end, wait_end, bit_val;
    logic                 last_bit, ack_last;

    // Clamp of the requested length (R5)
    always_comb begin
        if (nbits == '0)
            n_req = NB_W'(1);
        else if (nbits > NB_W'(MAX_BITS))
            n_req = NB_W'(MAX_BITS);
        else
            n_req = nbits;
    end

    assign in_window  = (state == S_BIT) || (state == S_SCAN);
    assign win_end    = in_window && (timer == TMR_W'(BIT_TICKS - 1));
    assign delay_last = mode_q ? TMR_W'(ACK_WAIT - 1) : TMR_W'(REPLY_WAIT - 1);
    assign wait_end   = (state == S_WAIT) && (timer == delay_last);
    assign bit_val    = (cnt_now > CNT_W'(EDGE_THRESH));
    assign last_bit   = (widx == WIDX_W'(nbits_q) - WIDX_W'(1));
    assign ack_last   = (widx == WIDX_W'(ACK_WINDOWS - 1));
    assign bit_mask   = MAX_BITS'(1) << widx;

    subcar_edge_cnt #(
        .CNT_W    (CNT_W)
    ) u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (cmp_in),
        .count_en (in_window),
        .clear    (!in_window || win_end),
        .cnt_now  (cnt_now)
    );

    subcar_step_cnt #(
        .BIT_TICKS (BIT_TICKS),
        .STEP_W    (STEP_W)
    ) u_steps (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state == S_IDLE),
        .steps_now (steps_now)
    );

    // Next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE: if (start) nstate = S_WAIT;                       // trigger
            S_WAIT: if (wait_end) nstate = mode_q ? S_SCAN : S_BIT;   // delay_done
            S_BIT:  if (win_end && last_bit) nstate = S_IDLE;         // frame_done
            S_SCAN: if (win_end && (bit_val || ack_last)) nstate = S_IDLE; // ack_hit / ack_timeout
            default: nstate = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nstate;
    end

    // Timing, capture and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer     <= '0;
            widx      <= '0;
            mode_q    <= 1'b0;
            nbits_q   <= '0;
            data_q    <= '0;
            done      <= 1'b0;
            data_out  <= '0;
            bits_out  <= '0;
            ack_ok    <= 1'b0;
            ack_steps <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        mode_q  <= ack_mode;
                        nbits_q <= n_req;
                        timer   <= '0;
                        widx    <= '0;
                        data_q  <= '0;
                    end
                end
                S_WAIT: begin
                    timer <= wait_end ? '0 : timer + TMR_W'(1);
                end
                S_BIT: begin
                    if (win_end) begin
                        timer <= '0;
                        widx  <= widx + WIDX_W'(1);
                        if (bit_val)
                            data_q <= data_q | bit_mask;
                        if (last_bit) begin
                            done      <= 1'b1;
                            data_out  <= bit_val ? (data_q | bit_mask) : data_q;
                            bits_out  <= nbits_q;
                            ack_ok    <= 1'b0;
                            ack_steps <= '0;
                        end
                    end else begin
                        timer <= timer + TMR_W'(1);
                    end
                end
                S_SCAN: begin
                    if (win_end) begin
                        timer <= '0;
                        widx  <= widx + WIDX_W'(1);
                        if (bit_val || ack_last) begin
                            done      <= 1'b1;
                            data_out  <= '0;
                            bits_out  <= '0;
                            ack_ok    <= bit_val;
                            ack_steps <= bit_val ? steps_now : '0;
                        end
                    end else begin
                        timer <= timer + TMR_W'(1);
                    end
                end
                default: timer <= '0;
            endcase
        end
    end
endmodule

// File: rtl/subcar_edge_rx_chk.sv
module subcar_edge_rx_chk #(
    parameter int BIT_TICKS   = 142,
    parameter int ACK_WAIT    = 5400,
    parameter int MAX_BITS    = 32,
    parameter int ACK_WINDOWS = 40,
    parameter int STEP_W      = 16,
    parameter int NB_W        = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                done,
    input logic [MAX_BITS-1:0] data_out,
    input logic [NB_W-1:0]     bits_out,
    input logic                ack_ok,
    input logic [STEP_W-1:0]   ack_steps
);
    localparam int STEP_MIN = (ACK_WAIT + BIT_TICKS) / BIT_TICKS;
    localparam int STEP_MAX = (ACK_WAIT + ACK_WINDOWS * BIT_TICKS) / BIT_TICKS;

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(data_out) && $stable(bits_out) && $stable(ack_ok) && $stable(ack_steps)));

    p_len_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bits_out <= NB_W'(MAX_BITS)));

    p_ack_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ack_ok) |-> (data_out == '0 && bits_out == '0));

    p_ack_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ack_ok) |-> (ack_steps >= STEP_W'(STEP_MIN) && ack_steps <= STEP_W'(STEP_MAX)));

    p_ack_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ack_ok && bits_out == '0) |-> (ack_steps == '0));

    p_reply_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && bits_out != '0) |-> (!ack_ok && ack_steps == '0));
endmodule

bind subcar_edge_rx subcar_edge_rx_chk #(
    .BIT_TICKS   (BIT_TICKS),
    .ACK_WAIT    (ACK_WAIT),
    .MAX_BITS    (MAX_BITS),
    .ACK_WINDOWS (ACK_WINDOWS),
    .STEP_W      (STEP_W),
    .NB_W        (NB_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .data_out  (data_out),
    .bits_out  (bits_out),
    .ack_ok    (ack_ok),
    .ack_steps (ack_steps)
);

// File: tb/subcar_edge_rx_tb.sv
module subcar_edge_rx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BITT  = 142;
    localparam int RWAIT = 477;
    localparam int AWAIT = 5400;
    localparam int THR   = 20;
    localparam int MAXB  = 32;
    localparam int AWIN  = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ack_mode = 1'b0;
    logic [5:0]  nbits = '0;
    logic        cmp_in = 1'b0;
    logic        done;
    logic [31:0] data_out;
    logic [5:0]  bits_out;
    logic        ack_ok;
    logic [15:0] ack_steps;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit finished = 0;
    int win_cnt [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    subcar_edge_rx u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ack_mode(ack_mode),
        .nbits(nbits), .cmp_in(cmp_in), .done(done), .data_out(data_out),
        .bits_out(bits_out), .ack_ok(ack_ok), .ack_steps(ack_steps)
    );

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: elapsed-time arithmetic, updated on each rising edge
    bit      m_busy = 0, m_mode = 0;
    bit      m_prev = 0;
    int      m_t = 0, m_delay = 0, m_nb = 0, m_edges = 0, m_widx = 0;
    longint  m_data = 0;
    bit      e_done = 0, e_ok = 0;
    longint  e_data = 0;
    int      e_bits = 0, e_steps = 0;

    always @(posedge clk) begin
        bit chg;
        chg = (cmp_in != m_prev);
        m_prev = cmp_in;
        e_done = 0;
        if (!rst_n) begin
            m_busy = 0; m_prev = 0; e_data = 0; e_bits = 0; e_ok = 0; e_steps = 0;
        end else if (!m_busy) begin
            if (start) begin
                m_busy = 1; m_t = 0; m_mode = ack_mode;
                m_nb = (nbits == 0) ? 1 : ((nbits > MAXB) ? MAXB : int'(nbits));
                m_delay = ack_mode ? AWAIT : RWAIT;
                m_edges = 0; m_widx = 0; m_data = 0;
            end
        end else begin
            m_t++;
            if (m_t > m_delay) begin
                if (chg) m_edges++;
                if ((m_t - m_delay) % BITT == 0) begin
                    bit b;
                    b = (m_edges > THR);
                    m_edges = 0;
                    if (!m_mode) begin
                        if (b) m_data = m_data | (longint'(1) << m_widx);
                        m_widx++;
                        if (m_widx == m_nb) begin
                            e_done = 1; e_data = m_data; e_bits = m_nb;
                            e_ok = 0; e_steps = 0; m_busy = 0;
                        end
                    end else begin
                        m_widx++;
                        if (b || m_widx == AWIN) begin
                            e_done = 1; e_data = 0; e_bits = 0; e_ok = b;
                            e_steps = b ? (m_t / BITT) : 0; m_busy = 0;
                        end
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            check("R9 model done", done, e_done);
            check("R4 model data_out", data_out, e_data);
            check("R4 model bits_out", bits_out, e_bits);
            check("R6 model ack_ok", ack_ok, e_ok);
            check("R6 model ack_steps", ack_steps, e_steps);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 190000 && !finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL R9 watchdog expired actual=%0d expected=<190000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Drive one reception; on return the bench sits at the falling edge that
    // follows the edge closing the last driven window.
    task automatic run(bit mode, int req, int nwin, bit noise, bit restart);
        int dly;
        dly = mode ? AWAIT : RWAIT;
        @(negedge clk);
        ack_mode = mode; nbits = 6'(req); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int d = 0; d < dly; d++) begin
            if (noise && (d % 3 == 0)) cmp_in = ~cmp_in;
            @(negedge clk);
        end
        for (int w = 0; w < nwin; w++) begin
            for (int j = 0; j < BITT; j++) begin
                if (j < win_cnt[w]) cmp_in = ~cmp_in;
                start = (restart && w == 1 && j == 5);
                @(negedge clk);
            end
        end
        start = 1'b0;
    endtask

    function automatic longint pattern(int n);
        longint v = 0;
        for (int i = 0; i < n; i++)
            if (win_cnt[i] > THR) v = v | (longint'(1) << i);
        return v;
    endfunction

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        // R1 reset state
        idle(3);
        check("R1 done in reset", done, 0);
        check("R1 data in reset", data_out, 0);
        rst_n = 1'b1;
        idle(3);
        check("R1 outputs after release", {ack_ok, bits_out, ack_steps}, 0);

        // R2 R4 six-bit reply with noise in the delay
        for (int i = 0; i < 6; i++) win_cnt[i] = (i % 2 == 0) ? 42 : 0;
        run(0, 6, 6, 1, 0);
        check("R2 done at end of 6th window", done, 1);
        check("R4 six-bit data", data_out, pattern(6));
        check("R4 six-bit count", bits_out, 6);
        check("R10 reply ack_ok", ack_ok, 0);
        idle(1);
        check("R9 done single cycle", done, 0);
        idle(4);

        // R3 threshold boundary inside a 12-bit reply
        for (int i = 0; i < 12; i++) win_cnt[i] = (i % 3 == 0) ? 21 : ((i % 3 == 1) ? 20 : 0);
        run(0, 12, 12, 0, 0);
        check("R3 threshold data", data_out, 64'h249);
        check("R3 done", done, 1);
        idle(5);

        // R4 full 32 bits
        for (int i = 0; i < 32; i++) win_cnt[i] = ((i * 7) % 5 < 2) ? 40 : 3;
        run(0, 32, 32, 0, 0);
        check("R4 32-bit data", data_out, pattern(32));
        check("R4 32-bit done", done, 1);
        idle(5);

        // R5 clamp above range
        for (int i = 0; i < 32; i++) win_cnt[i] = (i >= 30) ? 42 : 0;
        run(0, 40, 32, 0, 0);
        check("R5 clamp 40 to 32 done", done, 1);
        check("R5 clamp 40 count", bits_out, 32);
        check("R5 clamp 40 data", data_out, 64'hC000_0000);
        idle(5);

        // R5 zero request becomes one bit
        win_cnt[0] = 30;
        run(0, 0, 1, 0, 0);
        check("R5 zero request done", done, 1);
        check("R5 zero request count", bits_out, 1);
        check("R5 zero request data", data_out, 1);
        idle(5);

        // R8 retrigger during reception
        for (int i = 0; i < 6; i++) win_cnt[i] = (i < 3) ? 0 : 42;
        run(0, 6, 6, 0, 1);
        check("R8 ignored retrigger timing", done, 1);
        check("R8 ignored retrigger data", data_out, 64'h38);
        idle(700);
        check("R8 no second done", done, 0);
        check("R9 result held", data_out, 64'h38);

        // R6 acknowledge in first window
        win_cnt[0] = 42;
        run(1, 0, 1, 0, 0);
        check("R6 ack first done", done, 1);
        check("R6 ack first ok", ack_ok, 1);
        check("R6 ack first steps", ack_steps, (AWAIT + BITT) / BITT);
        check("R6 ack no data", bits_out, 0);
        idle(5);

        // R6 acknowledge in window 5
        for (int i = 0; i < 6; i++) win_cnt[i] = (i == 5) ? 42 : 20;
        run(1, 0, 6, 1, 0);
        check("R6 ack mid ok", ack_ok, 1);
        check("R6 ack mid steps", ack_steps, (AWAIT + 6 * BITT) / BITT);
        idle(5);

        // R6 acknowledge in last allowed window
        for (int i = 0; i < AWIN; i++) win_cnt[i] = (i == AWIN - 1) ? 25 : 5;
        run(1, 0, AWIN, 0, 0);
        check("R6 ack last ok", ack_ok, 1);
        check("R6 ack last steps", ack_steps, (AWAIT + AWIN * BITT) / BITT);
        idle(5);

        // R7 no acknowledge
        for (int i = 0; i < AWIN; i++) win_cnt[i] = (i % 4 == 0) ? 20 : 0;
        run(1, 0, AWIN, 0, 0);
        check("R7 fail done", done, 1);
        check("R7 fail ok", ack_ok, 0);
        check("R7 fail steps", ack_steps, 0);
        idle(5);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule